// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller Core

This block gathers fifteen interrupt request lines and presents each of up to sixteen processors with a 4-bit interrupt level. The block stores requests in one shared pending vector. It also keeps a private force vector for each processor, so that software, or a request marked for broadcast, can raise an interrupt on one processor without involving the others. A private mask vector for each processor decides which requests that processor sees. A global level-select vector places every request in a high or a low group, and any high-group candidate is served before every low-group candidate.

Software programs the block through a 32-bit bus that accepts word accesses only, at byte offsets in an 8-bit window. A processor that takes an interrupt raises its acknowledge strobe together with the level it took. The block then withdraws that request from the shared pending vector and from that processor's force vector. Request number 0 does not exist: bit 0 of every vector stays zero.

Top module: `mpic_core`

## Requirements
- R1: After a synchronous reset, every register reads zero and every processor level output is 0.
- R2: A rising edge on `irq_req[n]` (n from 1 to 15) sets pending bit n one cycle later when broadcast bit n is 0. Pending reads at offset 0x04.
- R3: A rising edge on `irq_req[n]` while broadcast bit n is 1 sets bit n in the force vector of every processor and leaves pending unchanged. The broadcast vector is at offset 0x14.
- R4: For each processor, the candidates are (pending OR force) AND mask. The level output is the index of the highest-numbered candidate in the served group, and it is 0 when there is no candidate. Masks are at offset 0x40 + 4*cpu.
- R5: A candidate whose level-select bit (offset 0x00) is 1 takes precedence over every candidate whose bit is 0.
- R6: A write to offset 0x80 + 4*cpu sets force to (old | data[15:1]) & ~data[31:17], using only that processor's force vector.
- R7: A write to offset 0x08 replaces processor 0's force vector with data[15:1]. Reads of 0x08 return processor 0's force vector.
- R8: A write to offset 0x0C removes the written bits from pending and from every force vector. Offset 0x0C always reads zero.
- R9: An acknowledge from processor c with level n clears bit n in pending and in processor c's force vector, and leaves the other force vectors unchanged.
- R10: Writes to pending are ignored. Misaligned or unmapped offsets read zero and ignore writes, including mask and force offsets of processors beyond NUM_CPU.
- R11: Bit 0 is dropped by every write and never set by `irq_req[0]`, so it always reads zero.
- R12: The level output changes on the cycle after the write, edge or acknowledge that caused the change. When a request edge and a clear land on the same bit in the same cycle, the request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 16 | Request lines; bit 0 unused |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational; zero when not reading) |
| ack_valid | input | NUM_CPU | Per-processor acknowledge strobe |
| ack_level | input | 4*NUM_CPU | Per-processor acknowledged level |
| cpu_level | output | 4*NUM_CPU | Per-processor encoded interrupt level |

## Verification
The hardest case to reach from the ports is a collision: a request edge, a clear write and an acknowledge all hit the same bit in the same cycle, while broadcast and level-select settings push the same request into different force vectors with different group membership. Directed steps set up each collision on purpose, including an edge that lands in the same cycle as a clear. A long pseudo-random phase then toggles request lines, issues acknowledges and writes every mapped and unmapped offset together. A behavioural model is compared with every level output on every clock and with every read.

// File: rtl/mpic_pkg.sv
package mpic_pkg;

    localparam int IRQ_N = 16;
    localparam int LVL_W = 4;
    localparam int MAX_CPU = 16;

    typedef logic [IRQ_N-1:0] irq_vec_t;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_LEVEL,
        ACC_PEND,
        ACC_FRC0,
        ACC_CLR,
        ACC_BCAST,
        ACC_MASK,
        ACC_FRC
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e        kind;
        logic [LVL_W-1:0] cpu;
    } acc_dec_t;

    // Request 0 does not exist; every stored vector keeps it at zero.
    function automatic irq_vec_t strip0(logic [IRQ_N-1:0] v);
        return {v[IRQ_N-1:1], 1'b0};
    endfunction

    function automatic irq_vec_t lvl_bit(logic [LVL_W-1:0] l);
        return strip0(irq_vec_t'(1) << l);
    endfunction

    function automatic logic [LVL_W-1:0] top_index(irq_vec_t v);
        logic [LVL_W-1:0] r;
        r = '0;
        for (int i = 1; i < IRQ_N; i++) begin
            if (v[i]) r = LVL_W'(i);
        end
        return r;
    endfunction

    // Offset map: 0x00 group select, 0x04 pending, 0x08 cpu0 force alias,
    // 0x0C clear, 0x14 broadcast, 0x40+4c mask, 0x80+4c force.
    function automatic acc_dec_t decode_addr(logic [7:0] a, int ncpu);
        acc_dec_t d;
        d.kind = ACC_NONE;
        d.cpu  = a[5:2];
        if (a[1:0] == 2'b00) begin
            unique case (a[7:6])
                2'b01: if (int'(a[5:2]) < ncpu) d.kind = ACC_MASK;
                2'b10: if (int'(a[5:2]) < ncpu) d.kind = ACC_FRC;
                2'b00: begin
                    case (a[5:2])
                        4'h0:    d.kind = ACC_LEVEL;
                        4'h1:    d.kind = ACC_PEND;
                        4'h2:    d.kind = ACC_FRC0;
                        4'h3:    d.kind = ACC_CLR;
                        4'h5:    d.kind = ACC_BCAST;
                        default: d.kind = ACC_NONE;
                    endcase
                end
                default: d.kind = ACC_NONE;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/mpic_edge.sv
module mpic_edge
    import mpic_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_vec_t irq_req,
    input  irq_vec_t bcast_sel,
    output irq_vec_t set_pend,
    output irq_vec_t set_frc
);

    irq_vec_t req_q;
    irq_vec_t rise;

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= irq_req;
    end

    always_comb begin
        rise     = strip0(irq_req & ~req_q);
        set_pend = rise & ~bcast_sel;
        set_frc  = rise & bcast_sel;
    end

endmodule

// File: rtl/mpic_store.sv
module mpic_store
    import mpic_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  acc_dec_t                 dec,
    input  logic [31:0]              wdata,
    input  irq_vec_t                 set_pend,
    input  irq_vec_t                 set_frc,
    input  logic [NUM_CPU-1:0]       ack_valid,
    input  logic [NUM_CPU*LVL_W-1:0] ack_level,
    output irq_vec_t                 level_sel,
    output irq_vec_t                 bcast_sel,
    output irq_vec_t                 pending,
    output logic [NUM_CPU*IRQ_N-1:0] mask_flat,
    output logic [NUM_CPU*IRQ_N-1:0] force_flat,
    output logic [31:0]              rdata
);

    irq_vec_t lvl_q, bc_q, pend_q, pend_n;
    irq_vec_t mask_q [NUM_CPU];
    irq_vec_t frc_q  [NUM_CPU];
    irq_vec_t frc_n  [NUM_CPU];
    irq_vec_t clr_vec, ack_any, set_bits, drop_bits;
    logic     wr_clr;

    assign wr_clr    = wr_en && (dec.kind == ACC_CLR);
    assign clr_vec   = wr_clr ? strip0(wdata[15:0]) : '0;
    assign set_bits  = strip0(wdata[15:0]);
    assign drop_bits = strip0(wdata[31:16]);

    always_comb begin
        ack_any = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (ack_valid[c]) ack_any = ack_any | lvl_bit(ack_level[c*LVL_W +: LVL_W]);
        end
        // Clears first, a request edge in the same cycle wins.
        pend_n = (pend_q & ~clr_vec & ~ack_any) | set_pend;
    end

    always_comb begin
        for (int c = 0; c < NUM_CPU; c++) begin
            frc_n[c] = frc_q[c];
            if (wr_en && dec.kind == ACC_FRC && dec.cpu == LVL_W'(c))
                frc_n[c] = (frc_n[c] | set_bits) & ~drop_bits;
            if (wr_en && dec.kind == ACC_FRC0 && c == 0)
                frc_n[c] = set_bits;
            frc_n[c] = frc_n[c] & ~clr_vec;
            if (ack_valid[c])
                frc_n[c] = frc_n[c] & ~lvl_bit(ack_level[c*LVL_W +: LVL_W]);
            frc_n[c] = frc_n[c] | set_frc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= '0;
            bc_q   <= '0;
            pend_q <= '0;
            for (int c = 0; c < NUM_CPU; c++) begin
                mask_q[c] <= '0;
                frc_q[c]  <= '0;
            end
        end else begin
            if (wr_en && dec.kind == ACC_LEVEL) lvl_q <= set_bits;
            if (wr_en && dec.kind == ACC_BCAST) bc_q  <= set_bits;
            pend_q <= pend_n;
            for (int c = 0; c < NUM_CPU; c++) begin
                if (wr_en && dec.kind == ACC_MASK && dec.cpu == LVL_W'(c))
                    mask_q[c] <= set_bits;
                frc_q[c] <= frc_n[c];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (dec.kind)
                ACC_LEVEL: rdata = {16'h0, lvl_q};
                ACC_PEND:  rdata = {16'h0, pend_q};
                ACC_FRC0:  rdata = {16'h0, frc_q[0]};
                ACC_BCAST: rdata = {16'h0, bc_q};
                ACC_MASK, ACC_FRC: begin
                    for (int c = 0; c < NUM_CPU; c++) begin
                        if (dec.cpu == LVL_W'(c))
                            rdata = {16'h0, (dec.kind == ACC_MASK) ? mask_q[c] : frc_q[c]};
                    end
                end
                default:   rdata = '0;
            endcase
        end
    end

    assign level_sel = lvl_q;
    assign bcast_sel = bc_q;
    assign pending   = pend_q;

    generate
        for (genvar g = 0; g < NUM_CPU; g++) begin : g_flat
            assign mask_flat[g*IRQ_N +: IRQ_N]  = mask_q[g];
            assign force_flat[g*IRQ_N +: IRQ_N] = frc_q[g];

            // R9: an acknowledge removes the level from this processor's force vector
            p_ack_force_r9: assert property (@(posedge clk) disable iff (rst)
                (ack_valid[g] && !(wr_en && ((dec.kind == ACC_FRC && dec.cpu == LVL_W'(g)) ||
                                             (dec.kind == ACC_FRC0 && g == 0))))
                |=> ((frc_q[g] & $past(lvl_bit(ack_level[g*LVL_W +: LVL_W])) & ~$past(set_frc)) == '0));

            // R3: broadcast edges land in every force vector
            p_bcast_all_r3: assert property (@(posedge clk) disable iff (rst)
                (set_frc != '0) |=> ((frc_q[g] & $past(set_frc)) == $past(set_frc)));
        end
    endgenerate

    // R2: a non-broadcast edge is recorded in pending
    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (set_pend != '0) |=> ((pend_q & $past(set_pend)) == $past(set_pend)));

    // R10: a bus write to pending has no effect
    p_pend_ro_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.kind == ACC_PEND && set_pend == '0 && ack_valid == '0) |=> $stable(pend_q));

    // R8: cleared bits are gone unless a same-cycle edge restored them
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((pend_q & $past(clr_vec) & ~$past(set_pend)) == '0));

    // R3: a broadcast edge does not touch pending
    p_bcast_nopend_r3: assert property (@(posedge clk) disable iff (rst)
        (set_frc != '0 && set_pend == '0 && !wr_clr && ack_valid == '0) |=> $stable(pend_q));

endmodule

// File: rtl/mpic_prio.sv
module mpic_prio
    import mpic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  irq_vec_t         pending,
    input  irq_vec_t         force_v,
    input  irq_vec_t         mask_v,
    input  irq_vec_t         level_sel,
    output logic [LVL_W-1:0] lvl_out
);

    irq_vec_t cand, hi_c, lo_c, pick;

    always_comb begin
        cand = (pending | force_v) & mask_v;
        hi_c = cand & level_sel;
        lo_c = cand & ~level_sel;
        pick = (hi_c != '0) ? hi_c : lo_c;
    end

    assign lvl_out = top_index(pick);

    // R4: no candidate, no level
    p_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (cand == '0) |-> (lvl_out == '0));

    // R4: the presented level is a real candidate
    p_member_r4: assert property (@(posedge clk) disable iff (rst)
        (cand != '0) |-> cand[lvl_out]);

    // R5: a high-group candidate always wins
    p_group_r5: assert property (@(posedge clk) disable iff (rst)
        ((cand & level_sel) != '0) |-> level_sel[lvl_out]);

endmodule

// File: rtl/mpic_core.sv
module mpic_core
    import mpic_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [15:0]              irq_req,
    input  logic                     bus_en,
    input  logic                     bus_we,
    input  logic [7:0]               bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic [NUM_CPU-1:0]       ack_valid,
    input  logic [NUM_CPU*4-1:0]     ack_level,
    output logic [NUM_CPU*4-1:0]     cpu_level
);

    initial begin
        if (NUM_CPU < 1 || NUM_CPU > MAX_CPU)
            $error("mpic_core: NUM_CPU out of range");
    end

    acc_dec_t                 dec;
    logic                     wr_en, rd_en;
    irq_vec_t                 set_pend, set_frc, level_sel, bcast_sel, pending;
    logic [NUM_CPU*IRQ_N-1:0] mask_flat, force_flat;

    assign dec   = decode_addr(bus_addr, NUM_CPU);
    assign wr_en = bus_en && bus_we;
    assign rd_en = bus_en && !bus_we;

    mpic_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .irq_req   (irq_req),
        .bcast_sel (bcast_sel),
        .set_pend  (set_pend),
        .set_frc   (set_frc)
    );

    mpic_store #(.NUM_CPU(NUM_CPU)) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .dec        (dec),
        .wdata      (bus_wdata),
        .set_pend   (set_pend),
        .set_frc    (set_frc),
        .ack_valid  (ack_valid),
        .ack_level  (ack_level),
        .level_sel  (level_sel),
        .bcast_sel  (bcast_sel),
        .pending    (pending),
        .mask_flat  (mask_flat),
        .force_flat (force_flat),
        .rdata      (bus_rdata)
    );

    generate
        for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
            mpic_prio u_prio (
                .clk       (clk),
                .rst       (rst),
                .pending   (pending),
                .force_v   (force_flat[g*IRQ_N +: IRQ_N]),
                .mask_v    (mask_flat[g*IRQ_N +: IRQ_N]),
                .level_sel (level_sel),
                .lvl_out   (cpu_level[g*LVL_W +: LVL_W])
            );
        end
    endgenerate

endmodule

// File: tb/mpic_core_test.sv
module mpic_core_test;

    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   irq_req = '0;
    logic          bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NC-1:0] ack_valid = '0;
    logic [NC*4-1:0] ack_level = '0;
    logic [NC*4-1:0] cpu_level;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    mpic_core #(.NUM_CPU(NC)) uut (
        .clk(clk), .rst(rst), .irq_req(irq_req),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ack_valid(ack_valid), .ack_level(ack_level), .cpu_level(cpu_level)
    );

    // Behavioural reference model
    bit [31:0] m_pend, m_lvl, m_bc, m_prev;
    bit [31:0] m_mask [NC];
    bit [31:0] m_frc  [NC];
    bit [31:0] t_rise, t_clr, t_ack, t_d, t_f;
    int        t_a;

    always @(posedge clk) begin
        if (rst) begin
            m_pend = 0; m_lvl = 0; m_bc = 0; m_prev = 0;
            for (int c = 0; c < NC; c++) begin m_mask[c] = 0; m_frc[c] = 0; end
        end else begin
            t_rise = {16'h0, irq_req} & ~m_prev & 32'hFFFE;
            t_d    = bus_wdata;
            t_a    = int'(bus_addr);
            t_clr  = (bus_en && bus_we && t_a == 12) ? (t_d & 32'hFFFE) : 0;
            t_ack  = 0;
            for (int c = 0; c < NC; c++)
                if (ack_valid[c]) t_ack |= (32'd1 << ack_level[c*4 +: 4]) & 32'hFFFE;
            for (int c = 0; c < NC; c++) begin
                t_f = m_frc[c];
                if (bus_en && bus_we && t_a == 128 + 4*c)
                    t_f = (t_f | (t_d & 32'hFFFE)) & ~((t_d >> 16) & 32'hFFFE);
                if (bus_en && bus_we && t_a == 8 && c == 0) t_f = t_d & 32'hFFFE;
                t_f &= ~t_clr;
                if (ack_valid[c]) t_f &= ~((32'd1 << ack_level[c*4 +: 4]) & 32'hFFFE);
                t_f |= t_rise & m_bc;
                m_frc[c] = t_f;
                if (bus_en && bus_we && t_a == 64 + 4*c) m_mask[c] = t_d & 32'hFFFE;
            end
            m_pend = (m_pend & ~t_clr & ~t_ack) | (t_rise & ~m_bc);
            if (bus_en && bus_we && t_a == 0)  m_lvl = t_d & 32'hFFFE;
            if (bus_en && bus_we && t_a == 20) m_bc  = t_d & 32'hFFFE;
            m_prev = {16'h0, irq_req};
        end
    end

    function automatic int exp_level(int c);
        bit [31:0] cand, sel;
        int r = 0;
        cand = (m_pend | m_frc[c]) & m_mask[c];
        sel  = ((cand & m_lvl) != 0) ? (cand & m_lvl) : cand;
        for (int i = 1; i < 16; i++) if (sel[i]) r = i;
        return r;
    endfunction

    function automatic bit [31:0] model_read(int a);
        if (a == 0)  return m_lvl;
        if (a == 4)  return m_pend;
        if (a == 8)  return m_frc[0];
        if (a == 20) return m_bc;
        for (int c = 0; c < NC; c++) begin
            if (a == 64 + 4*c)  return m_mask[c];
            if (a == 128 + 4*c) return m_frc[c];
        end
        return 0;
    endfunction

    // Every-clock comparison of all level outputs (R4, R5, R12)
    always @(posedge clk) begin
        #3;
        for (int c = 0; c < NC; c++) begin
            checks++;
            if (int'(cpu_level[c*4 +: 4]) != exp_level(c)) begin
                errors++;
                $display("FAIL R4/R5/R12 cpu%0d level: actual=%0d expected=%0d at %0t",
                         c, cpu_level[c*4 +: 4], exp_level(c), $time);
            end
        end
    end

    task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic bread(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s read 0x%02h: actual=0x%08h expected=0x%08h", req, a, bus_rdata, exp);
        end
        bus_en = 0;
    endtask

    task automatic chk_lvl(input int c, input int exp, input string req);
        @(negedge clk);
        #1;
        checks++;
        if (int'(cpu_level[c*4 +: 4]) != exp) begin
            errors++;
            $display("FAIL %s cpu%0d level: actual=%0d expected=%0d", req, c, cpu_level[c*4 +: 4], exp);
        end
    endtask

    task automatic pulse(input int n);
        @(negedge clk); irq_req[n] = 1'b1;
        @(negedge clk); irq_req[n] = 1'b0;
    endtask

    task automatic ack(input int c, input int l);
        @(negedge clk); ack_valid[c] = 1'b1; ack_level[c*4 +: 4] = 4'(l);
        @(negedge clk); ack_valid[c] = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    bit [31:0] lf = 32'h1ACE_B00C;
    function automatic bit [31:0] step(bit [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        // R1: reset state
        bread(8'h00, 0, "R1"); bread(8'h04, 0, "R1"); bread(8'h40, 0, "R1"); bread(8'h8C, 0, "R1");
        chk_lvl(0, 0, "R1");

        for (int c = 0; c < NC; c++) bwrite(8'(64 + 4*c), 32'hFFFF_FFFF);
        bread(8'h44, 32'hFFFE, "R11");

        pulse(5);
        bread(8'h04, 32'h0020, "R2"); chk_lvl(0, 5, "R4");
        pulse(0);
        bread(8'h04, 32'h0020, "R11");
        pulse(9);
        bread(8'h04, 32'h0220, "R2"); chk_lvl(2, 9, "R4");

        bwrite(8'h00, 32'h0000_0021);
        bread(8'h00, 32'h0020, "R11"); chk_lvl(0, 5, "R5");

        ack(1, 5);
        bread(8'h04, 32'h0200, "R9"); chk_lvl(0, 9, "R9");

        bwrite(8'h04, 32'hFFFF);
        bread(8'h04, 32'h0200, "R10");
        bwrite(8'h10, 32'hFFFF); bread(8'h10, 0, "R10");
        bwrite(8'h3C, 32'hFFFF); bread(8'h3C, 0, "R10");
        bwrite(8'h42, 32'h0); bread(8'h41, 0, "R10");
        bread(8'h44, 32'hFFFE, "R10");
        bwrite(8'h50, 32'hFFFF); bread(8'h50, 0, "R10");

        bwrite(8'h14, 32'h0801);
        bread(8'h14, 32'h0800, "R3");
        pulse(11);
        bread(8'h04, 32'h0200, "R3"); bread(8'h88, 32'h0800, "R3"); bread(8'h80, 32'h0800, "R3");
        chk_lvl(3, 11, "R3");

        ack(2, 11);
        bread(8'h88, 0, "R9"); bread(8'h80, 32'h0800, "R9");

        bwrite(8'h8C, 32'h0800_0007);
        bread(8'h8C, 32'h0006, "R6"); bread(8'h84, 32'h0800, "R6");

        bwrite(8'h08, 32'h0000_0011);
        bread(8'h80, 32'h0010, "R7"); bread(8'h08, 32'h0010, "R7");

        bwrite(8'h0C, 32'hFFFF);
        bread(8'h0C, 0, "R8"); bread(8'h04, 0, "R8"); bread(8'h80, 0, "R8"); bread(8'h8C, 0, "R8");
        chk_lvl(1, 0, "R8");

        bwrite(8'h44, 32'h0);
        pulse(7);
        chk_lvl(0, 7, "R4"); chk_lvl(1, 0, "R4");

        // R12: edge and clear on the same bit in the same cycle
        @(negedge clk);
        irq_req[3] = 1'b1; bus_en = 1; bus_we = 1; bus_addr = 8'h0C; bus_wdata = 32'h0088;
        @(negedge clk);
        bus_en = 0; bus_we = 0; irq_req[3] = 1'b0;
        bread(8'h04, 32'h0008, "R12");

        // Pseudo-random mix against the model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            lf = step(step(step(lf)));
            irq_req   = lf[15:0] & lf[31:16];
            ack_valid = (lf[7:5] == 3'b000) ? NC'(lf[11:8]) : '0;
            ack_level = NC*4'(lf[27:12]);
            bus_en = 0; bus_we = 0;
            if (lf[4:2] == 3'b000) begin
                bus_en = 1; bus_we = 1; bus_wdata = step(lf);
                case (lf[22:20])
                    3'd0: bus_addr = 8'h00;
                    3'd1: bus_addr = 8'h08;
                    3'd2: bus_addr = (lf[9:8] == 0) ? 8'h0C : 8'h04;
                    3'd3: bus_addr = 8'h14;
                    3'd4: bus_addr = 8'(64 + 4*int'(lf[25:24]));
                    3'd5: bus_addr = 8'(128 + 4*int'(lf[25:24]));
                    3'd6: bus_addr = 8'(128 + 4*int'(lf[25:24]));
                    default: bus_addr = 8'hC4;
                endcase
            end else if (lf[4:2] == 3'b001) begin
                bus_en = 1; bus_we = 0;
                bus_addr = {2'(lf[29:28]), 4'(lf[17:14]), 2'b00};
                #1;
                checks++;
                if (bus_rdata !== model_read(int'(bus_addr))) begin
                    errors++;
                    $display("FAIL R10/R2 random read 0x%02h: actual=0x%08h expected=0x%08h",
                             bus_addr, bus_rdata, model_read(int'(bus_addr)));
                end
            end
        end
        @(negedge clk);
        bus_en = 0; ack_valid = '0; irq_req = '0;
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule